// File: doc/BRIEF.md
# GPIO Expander Register Core

This block is the register and event core of a sixteen-line general purpose I/O expander. A serial slave front end turns bus transfers into single-byte accesses on a simple port: an address, write data with a write strobe, and a read strobe with combinational read data. Through that port the host sets each line's direction, output level, pull-up, pull-down and open-drain drive, and enables interrupts per line. The core drives the pad-control outputs from these settings.

Input pins pass through a synchronizer. Each line has a two-bit edge-sense code that selects rising edges, falling edges, both edges or none. Each enabled edge latches a bit in the interrupt-source register. The active-low interrupt output goes low while any latched bit is unmasked. The host clears source bits by writing ones back to them. A read of the data register also clears the source bits of the lines that the read covers, unless the host has turned that behaviour off. A keyed pair of writes to a fixed address resets every register without touching the hardware reset.

Registers wider than a byte occupy consecutive addresses, with the most significant byte (the highest-numbered lines) at the lowest address.

Top module: `gpx_core`

## Requirements
- R1: After reset, every line is an input and all of the following are zero: output latch, pull-up, pull-down, open-drain, sense, source and control. The mask is all ones, irq_n is high and pin_oe is zero.
- R2: A direction bit of 1 makes its line an input (pin_oe low). A direction bit of 0 makes it an output: pin_out carries the output latch, and pin_oe is high when open-drain is off.
- R3: An output line with its open-drain bit set drives (pin_oe high) only while its latch bit is 0.
- R4: Byte map, each register with the lower-numbered lines at the higher address: pull-up 0x00–0x01, pull-down 0x02–0x03, open-drain 0x04–0x05, direction 0x06–0x07, data 0x08–0x09, mask 0x0A–0x0B, sense 0x0C–0x0F, source 0x10–0x11, control 0x12. Address 0x0C holds lines 15..12 of sense. Line n's sense field sits at bits 2·(n mod 4) of its byte.
- R5: pull_up_en and pull_dn_en equal the pull-up and pull-down registers.
- R6: Sense code 01 latches rising edges, 10 latches falling edges, 11 latches both, and 00 latches none. Edges are detected only, never levels. A latched source bit shows, and irq_n responds, three clock edges after the pin changes.
- R7: Writing 1 to a source bit clears it, and writing 0 leaves it. An edge detected in the same cycle as a clear leaves the bit set.
- R8: A read strobe on a data byte clears the source bits of the eight lines in that byte, unless bit 0 of the control register is 1.
- R9: irq_n is low exactly when some source bit is set whose mask bit is 0.
- R10: A data read returns the synchronized pin level for input lines and the output latch for output lines.
- R11: Writing 0x12 and then 0x34 to address 0x7D, as two consecutive writes, returns every register to its R1 value. Any other write between the two, or 0x34 written alone, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Byte address of the access |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe, one cycle per byte written |
| reg_re | input | 1 | Read strobe, one cycle per byte read |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| pin_in | input | 16 | Raw pin levels, asynchronous |
| pin_out | output | 16 | Output latch to the pads |
| pin_oe | output | 16 | Per-line pad drive enable |
| pull_up_en | output | 16 | Per-line pull-up enable |
| pull_dn_en | output | 16 | Per-line pull-down enable |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The checks assume that reg_we and reg_re are never high in the same cycle. They also assume that a strobe lasts exactly one clock per byte. The bench's access tasks raise a single strobe at a falling edge and drop it at the next falling edge. Pins change only at falling edges, so the synchronizer latency stays a fixed three cycles and the same-cycle set-versus-clear case can be placed on an exact edge.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
   localparam logic [7:0] KEY_ARM  = 8'h12;
   localparam logic [7:0] KEY_FIRE = 8'h34;
   localparam int         KEY_ADDR = 8'h7D;

   typedef enum logic {KEY_IDLE, KEY_ARMED} key_state_e;

   // sense code bit 0 selects rising, bit 1 selects falling
   function automatic logic edge_hit(input logic [1:0] code, input logic now_lvl,
                                     input logic old_lvl);
      return (code[0] & now_lvl & ~old_lvl) | (code[1] & ~now_lvl & old_lvl);
   endfunction
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
   parameter int W      = 16,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad
      $error("gpx_sync needs at least two stages");
   end

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= '0;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpx_edge.sv
module gpx_edge #(
   parameter int NLINES = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                soft_rst,
   input  logic [NLINES-1:0]   lvl,
   input  logic [2*NLINES-1:0] sense,
   input  logic [NLINES-1:0]   clr,
   output logic [NLINES-1:0]   src
);
   import gpx_pkg::*;

   logic [NLINES-1:0] lvl_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_d <= '0;
      else        lvl_d <= lvl;
   end

   for (genvar n = 0; n < NLINES; n++) begin : g_line
      logic hit;
      logic bit_q;
      assign hit = edge_hit(sense[2*n +: 2], lvl[n], lvl_d[n]);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        bit_q <= 1'b0;
         else if (soft_rst) bit_q <= 1'b0;
         else if (hit)      bit_q <= 1'b1;   // a new edge beats a clear
         else if (clr[n])   bit_q <= 1'b0;
      end
      assign src[n] = bit_q;
   end
endmodule

// File: rtl/gpx_regs.sv
module gpx_regs #(
   parameter int NLINES = 16,
   parameter int ADDR_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [7:0]          wdata,
   input  logic                we,
   input  logic                re,
   output logic [7:0]          rdata,
   input  logic [NLINES-1:0]   lvl,
   input  logic [NLINES-1:0]   src,
   output logic [NLINES-1:0]   dir_q,
   output logic [NLINES-1:0]   data_q,
   output logic [NLINES-1:0]   pu_q,
   output logic [NLINES-1:0]   pd_q,
   output logic [NLINES-1:0]   od_q,
   output logic [NLINES-1:0]   mask_q,
   output logic [2*NLINES-1:0] sense_q,
   output logic [NLINES-1:0]   clr,
   output logic                soft_rst
);
   import gpx_pkg::*;

   localparam int NB      = NLINES / 8;
   localparam int SB      = NLINES / 4;
   localparam int A_PU    = 0;
   localparam int A_PD    = A_PU + NB;
   localparam int A_OD    = A_PD + NB;
   localparam int A_DIR   = A_OD + NB;
   localparam int A_DATA  = A_DIR + NB;
   localparam int A_MASK  = A_DATA + NB;
   localparam int A_SENSE = A_MASK + NB;
   localparam int A_SRC   = A_SENSE + SB;
   localparam int A_CTRL  = A_SRC + NB;

   if (NLINES % 8 != 0 || NLINES < 8) begin : g_bad_lines
      $error("NLINES must be a non-zero multiple of 8");
   end
   if (A_CTRL >= KEY_ADDR || KEY_ADDR >= (1 << ADDR_W)) begin : g_bad_map
      $error("register map collides with the reset key address");
   end

   logic [7:0]        ctrl_q;
   key_state_e        key_q;
   logic [NLINES-1:0] data_view;
   int                a;

   assign a         = int'(addr);
   assign soft_rst  = we && (a == KEY_ADDR) && (wdata == KEY_FIRE) && (key_q == KEY_ARMED);
   assign data_view = (dir_q & lvl) | (~dir_q & data_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_q <= KEY_IDLE;
      end else if (we) begin
         key_q <= (a == KEY_ADDR && wdata == KEY_ARM) ? KEY_ARMED : KEY_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q   <= '1;
         data_q  <= '0;
         pu_q    <= '0;
         pd_q    <= '0;
         od_q    <= '0;
         mask_q  <= '1;
         sense_q <= '0;
         ctrl_q  <= '0;
      end else if (soft_rst) begin
         dir_q   <= '1;
         data_q  <= '0;
         pu_q    <= '0;
         pd_q    <= '0;
         od_q    <= '0;
         mask_q  <= '1;
         sense_q <= '0;
         ctrl_q  <= '0;
      end else if (we) begin
         for (int k = 0; k < NB; k++) begin
            if (a == A_PU + k)   pu_q[(NB-1-k)*8 +: 8]   <= wdata;
            if (a == A_PD + k)   pd_q[(NB-1-k)*8 +: 8]   <= wdata;
            if (a == A_OD + k)   od_q[(NB-1-k)*8 +: 8]   <= wdata;
            if (a == A_DIR + k)  dir_q[(NB-1-k)*8 +: 8]  <= wdata;
            if (a == A_DATA + k) data_q[(NB-1-k)*8 +: 8] <= wdata;
            if (a == A_MASK + k) mask_q[(NB-1-k)*8 +: 8] <= wdata;
         end
         for (int k = 0; k < SB; k++) begin
            if (a == A_SENSE + k) sense_q[(SB-1-k)*8 +: 8] <= wdata;
         end
         if (a == A_CTRL) ctrl_q <= wdata;
      end
   end

   // clear requests: write-one-to-clear on source bytes, read of data bytes
   always_comb begin
      clr = '0;
      for (int k = 0; k < NB; k++) begin
         if (we && a == A_SRC + k)
            clr[(NB-1-k)*8 +: 8] = wdata;
         if (re && a == A_DATA + k && !ctrl_q[0])
            clr[(NB-1-k)*8 +: 8] = '1;
      end
   end

   always_comb begin
      rdata = '0;
      for (int k = 0; k < NB; k++) begin
         if (a == A_PU + k)   rdata = pu_q[(NB-1-k)*8 +: 8];
         if (a == A_PD + k)   rdata = pd_q[(NB-1-k)*8 +: 8];
         if (a == A_OD + k)   rdata = od_q[(NB-1-k)*8 +: 8];
         if (a == A_DIR + k)  rdata = dir_q[(NB-1-k)*8 +: 8];
         if (a == A_DATA + k) rdata = data_view[(NB-1-k)*8 +: 8];
         if (a == A_MASK + k) rdata = mask_q[(NB-1-k)*8 +: 8];
         if (a == A_SRC + k)  rdata = src[(NB-1-k)*8 +: 8];
      end
      for (int k = 0; k < SB; k++) begin
         if (a == A_SENSE + k) rdata = sense_q[(SB-1-k)*8 +: 8];
      end
      if (a == A_CTRL) rdata = ctrl_q;
   end
endmodule

// File: rtl/gpx_core.sv
module gpx_core #(
   parameter int NLINES      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        reg_addr,
   input  logic [7:0]        reg_wdata,
   input  logic              reg_we,
   input  logic              reg_re,
   output logic [7:0]        reg_rdata,
   input  logic [NLINES-1:0] pin_in,
   output logic [NLINES-1:0] pin_out,
   output logic [NLINES-1:0] pin_oe,
   output logic [NLINES-1:0] pull_up_en,
   output logic [NLINES-1:0] pull_dn_en,
   output logic              irq_n
);
   logic [NLINES-1:0]   lvl;
   logic [NLINES-1:0]   src_q;
   logic [NLINES-1:0]   dir_q;
   logic [NLINES-1:0]   data_q;
   logic [NLINES-1:0]   pu_q;
   logic [NLINES-1:0]   pd_q;
   logic [NLINES-1:0]   od_q;
   logic [NLINES-1:0]   mask_q;
   logic [2*NLINES-1:0] sense_q;
   logic [NLINES-1:0]   clr;
   logic                soft_rst;

   gpx_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(lvl)
   );

   gpx_regs #(.NLINES(NLINES), .ADDR_W(8)) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wdata(reg_wdata),
      .we(reg_we), .re(reg_re), .rdata(reg_rdata), .lvl(lvl), .src(src_q),
      .dir_q(dir_q), .data_q(data_q), .pu_q(pu_q), .pd_q(pd_q), .od_q(od_q),
      .mask_q(mask_q), .sense_q(sense_q), .clr(clr), .soft_rst(soft_rst)
   );

   gpx_edge #(.NLINES(NLINES)) u_edge (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .lvl(lvl),
      .sense(sense_q), .clr(clr), .src(src_q)
   );

   for (genvar n = 0; n < NLINES; n++) begin : g_pad
      assign pin_oe[n] = ~dir_q[n] & (~od_q[n] | ~data_q[n]);
   end

   assign pin_out    = data_q;
   assign pull_up_en = pu_q;
   assign pull_dn_en = pd_q;
   assign irq_n      = ~|(src_q & ~mask_q);
endmodule

// File: rtl/gpx_chk.sv
module gpx_chk #(
   parameter int NLINES = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic                irq_n,
   input logic [NLINES-1:0]   pin_oe,
   input logic [NLINES-1:0]   src_q,
   input logic [NLINES-1:0]   mask_q,
   input logic [NLINES-1:0]   dir_q,
   input logic [2*NLINES-1:0] sense_q,
   input logic                soft_rst
);
   // R9
   irq_low_when_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(src_q & ~mask_q)) |-> !irq_n);

   // R9
   irq_high_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(src_q & ~mask_q)) |-> irq_n);

   // R6
   no_event_without_sense_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_q == '0 && src_q == '0) |=> src_q == '0);

   // R2
   inputs_never_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_q == '1) |-> (pin_oe == '0));

   // R11
   key_reset_restores_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (mask_q == '1 && sense_q == '0 && dir_q == '1 && src_q == '0));
endmodule

bind gpx_core gpx_chk #(.NLINES(NLINES)) u_chk (
   .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .pin_oe(pin_oe), .src_q(src_q),
   .mask_q(mask_q), .dir_q(dir_q), .sense_q(sense_q), .soft_rst(soft_rst)
);

// File: tb/tb_gpx_core.sv
module tb_gpx_core;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic        reg_we = 1'b0;
   logic        reg_re = 1'b0;
   logic [7:0]  reg_rdata;
   logic [15:0] pin_in = '0;
   logic [15:0] pin_out, pin_oe, pull_up_en, pull_dn_en;
   logic        irq_n;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   gpx_core dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .pull_up_en(pull_up_en),
      .pull_dn_en(pull_dn_en), .irq_n(irq_n)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic hw_reset();
      @(negedge clk);
      rst_n = 1'b0; reg_we = 1'b0; reg_re = 1'b0; pin_in = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] v);
      @(negedge clk);
      reg_addr = a; reg_re = 1'b1;
      #1 v = reg_rdata;
      @(negedge clk);
      reg_re = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
      logic [7:0] v;
      rd(a, v);
      chk(tag, {24'h0, v}, {24'h0, exp});
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset();
      hw_reset();
      chk("R1 irq_n", {31'h0, irq_n}, 32'h1);
      chk("R1 pin_oe", {16'h0, pin_oe}, 32'h0);
      rd_chk("R1 pullup hi", 8'h00, 8'h00);
      rd_chk("R1 pulldn lo", 8'h03, 8'h00);
      rd_chk("R1 drain hi", 8'h04, 8'h00);
      rd_chk("R1 dir hi", 8'h06, 8'hFF);
      rd_chk("R1 dir lo", 8'h07, 8'hFF);
      rd_chk("R1 mask hi", 8'h0A, 8'hFF);
      rd_chk("R1 mask lo", 8'h0B, 8'hFF);
      rd_chk("R1 sense", 8'h0D, 8'h00);
      rd_chk("R1 src", 8'h11, 8'h00);
      rd_chk("R1 ctrl", 8'h12, 8'h00);
   endtask

   task automatic t_layout();
      hw_reset();
      wr(8'h00, 8'hA5); wr(8'h01, 8'h3C);
      chk("R5 R4 pull_up_en byte order", {16'h0, pull_up_en}, 32'h0000_A53C);
      wr(8'h02, 8'h81);
      chk("R5 pull_dn_en", {16'h0, pull_dn_en}, 32'h0000_8100);
      wr(8'h0C, 8'h11); wr(8'h0D, 8'h22); wr(8'h0E, 8'h33); wr(8'h0F, 8'h44);
      rd_chk("R4 sense 0x0C", 8'h0C, 8'h11);
      rd_chk("R4 sense 0x0F", 8'h0F, 8'h44);
   endtask

   task automatic t_direction();
      hw_reset();
      wr(8'h06, 8'hF0); wr(8'h08, 8'hC3);
      chk("R2 pin_oe outputs", {16'h0, pin_oe}, 32'h0000_0F00);
      chk("R2 pin_out latch", {16'h0, pin_out}, 32'h0000_C300);
      wr(8'h04, 8'h0F);
      chk("R3 open-drain enables", {16'h0, pin_oe}, 32'h0000_0C00);
   endtask

   task automatic t_data_read();
      hw_reset();
      pin_in = 16'h1234;
      settle(3);
      rd_chk("R10 input hi", 8'h08, 8'h12);
      rd_chk("R10 input lo", 8'h09, 8'h34);
      wr(8'h07, 8'h00); wr(8'h09, 8'h5A);
      rd_chk("R10 output lo", 8'h09, 8'h5A);
      rd_chk("R10 input hi kept", 8'h08, 8'h12);
   endtask

   task automatic t_edges();
      hw_reset();
      wr(8'h0A, 8'h00); wr(8'h0B, 8'h00);
      wr(8'h0F, 8'h81);   // line0 rise, line3 fall
      wr(8'h0E, 8'h0C);   // line5 both
      wr(8'h0C, 8'h01);   // line12 rise
      @(negedge clk);
      pin_in = 16'h1001;
      settle(2);
      chk("R6 latency not yet", {31'h0, irq_n}, 32'h1);
      settle(1);
      chk("R6 latency third edge", {31'h0, irq_n}, 32'h0);
      rd_chk("R6 rise line12", 8'h10, 8'h10);
      rd_chk("R6 rise line0", 8'h11, 8'h01);
      pin_in = 16'h1009; settle(4);
      rd_chk("R6 fall-only ignores rise", 8'h11, 8'h01);
      pin_in = 16'h1001; settle(4);
      rd_chk("R6 fall line3", 8'h11, 8'h09);
      pin_in = 16'h1021; settle(4);
      rd_chk("R6 both rise line5", 8'h11, 8'h29);
      wr(8'h11, 8'h20);
      pin_in = 16'h1001; settle(4);
      rd_chk("R6 both fall line5", 8'h11, 8'h29);
      pin_in = 16'h1003; settle(4);
      pin_in = 16'h1001; settle(4);
      rd_chk("R6 code 00 line1", 8'h11, 8'h29);
   endtask

   task automatic t_clear();
      hw_reset();
      wr(8'h0B, 8'h00);
      wr(8'h0F, 8'h07);   // line0 both, line1 rise
      @(negedge clk);
      pin_in = 16'h0003; settle(4);
      rd_chk("R7 both set", 8'h11, 8'h03);
      @(negedge clk);
      pin_in = 16'h0002;          // line0 falls, detected at third edge
      settle(2);
      reg_addr = 8'h11; reg_wdata = 8'h03; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
      rd_chk("R7 set wins over clear", 8'h11, 8'h01);
      wr(8'h11, 8'h00);
      rd_chk("R7 zero write keeps", 8'h11, 8'h01);
      wr(8'h11, 8'h01);
      rd_chk("R7 one write clears", 8'h11, 8'h00);
      chk("R7 irq released", {31'h0, irq_n}, 32'h1);
   endtask

   task automatic t_autoclear();
      logic [7:0] v;
      hw_reset();
      wr(8'h0F, 8'h10);   // line2 rise
      wr(8'h0D, 8'h10);   // line10 rise
      @(negedge clk);
      pin_in = 16'h0404; settle(4);
      rd(8'h08, v);
      rd_chk("R8 hi byte cleared", 8'h10, 8'h00);
      rd_chk("R8 lo byte untouched", 8'h11, 8'h04);
      wr(8'h12, 8'h01);
      rd(8'h09, v);
      rd_chk("R8 control bit blocks clear", 8'h11, 8'h04);
      wr(8'h12, 8'h00);
      rd(8'h09, v);
      rd_chk("R8 clear restored", 8'h11, 8'h00);
   endtask

   task automatic t_mask();
      hw_reset();
      wr(8'h0E, 8'h10);   // line6 rise
      @(negedge clk);
      pin_in = 16'h0040; settle(4);
      rd_chk("R9 src latched while masked", 8'h11, 8'h40);
      chk("R9 masked irq high", {31'h0, irq_n}, 32'h1);
      wr(8'h0B, 8'hBF);
      chk("R9 unmasked irq low", {31'h0, irq_n}, 32'h0);
      wr(8'h0B, 8'hFF); wr(8'h0A, 8'h00);
      chk("R9 other byte unmask irq high", {31'h0, irq_n}, 32'h1);
   endtask

   task automatic t_keyed();
      hw_reset();
      wr(8'h0B, 8'h00); wr(8'h06, 8'h00);
      wr(8'h7D, 8'h34);
      rd_chk("R11 lone second key", 8'h0B, 8'h00);
      wr(8'h7D, 8'h12); wr(8'h7D, 8'h55); wr(8'h7D, 8'h34);
      rd_chk("R11 wrong middle value", 8'h0B, 8'h00);
      wr(8'h7D, 8'h12); wr(8'h00, 8'h01); wr(8'h7D, 8'h34);
      rd_chk("R11 other write aborts", 8'h0B, 8'h00);
      rd_chk("R11 intervening write kept", 8'h00, 8'h01);
      wr(8'h7D, 8'h12); wr(8'h7D, 8'h34);
      rd_chk("R11 mask restored", 8'h0B, 8'hFF);
      rd_chk("R11 dir restored", 8'h06, 8'hFF);
      rd_chk("R11 pullup restored", 8'h00, 8'h00);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_layout();
      t_direction();
      t_data_read();
      t_edges();
      t_clear();
      t_autoclear();
      t_mask();
      t_keyed();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule